// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital half of one successive-approximation conversion. It watches an active-low chip-select and a read/convert line, which are merged by OR into a single active-low request. A high-to-low transition of that merged request starts a conversion, so it does not matter which of the two lines falls last. While the conversion runs, the block presents a trial word to an external DAC and comparator. After each bit period it reads back one comparator decision and resolves one bit, starting at the most significant bit.

A ready output is low for the whole conversion. It returns high in the same cycle that the finished word is written into the result register and a one-cycle load strobe fires. If the merged request is still low when ready returns, a new conversion begins on the very next cycle, with no acquisition gap. A power-down input blocks new starts but leaves the stored result untouched. Both control inputs pass through a configurable synchronizer chain before they are used. The length of a bit period in clocks is a parameter, so the total conversion time can be fitted to the analog settling budget.

Top module: `sar_seq_ctrl`

## Requirements
- R1: In reset, and in the first cycle after reset, conv_ready is 1, result_load is 0, and result_word and trial_word are both 0.
- R2: The merged request (cs_n OR rc), delayed by SYNC_STAGES clocks, starts a conversion when it goes from 1 to 0 while the synchronized pwrdn is 0. Either a falling rc with cs_n low or a falling cs_n with rc low counts.
- R3: conv_ready falls in the cycle after the start is seen. It then stays low for exactly RES_BITS*TICKS_PER_BIT cycles.
- R4: On start, trial_word is set to the MSB alone. Every TICKS_PER_BIT cycles the current bit is kept if cmp_hi=1 and cleared if cmp_hi=0, and the next lower bit is set. For a comparator that reports 1 when trial_word <= input, the final result equals the input.
- R5: result_load is a single-cycle pulse, issued in the same cycle that conv_ready returns to 1. In that cycle result_word carries the new result.
- R6: result_word changes only in a cycle where result_load is 1.
- R7: A falling merged request that arrives while conv_ready is 0 is ignored and does not cause a later start.
- R8: If the synchronized merged request is 0 in the cycle that conv_ready returns to 1, and pwrdn is 0, a new conversion starts. In that case conv_ready is high for exactly one cycle.
- R9: While the synchronized pwrdn is 1, no conversion starts, and a request edge seen in that time is lost. A conversion already in progress runs to completion.
- R10: trial_word is 0 whenever conv_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, merged by OR with rc |
| rc | input | 1 | Read/convert line; low is the convert level |
| pwrdn | input | 1 | Power-down; high blocks new conversions |
| cmp_hi | input | 1 | Comparator decision: 1 means input at or above trial_word |
| trial_word | output | RES_BITS | Trial code sent to the DAC |
| conv_ready | output | 1 | High when idle, low while a conversion runs |
| result_word | output | RES_BITS | Last completed conversion result |
| result_load | output | 1 | One-cycle strobe when result_word is written |

## Verification
A wrong bit index or a wrong keep/clear decision in the search register shows up on trial_word within one bit period. It also gives a result_word that differs from the applied input value when the load strobe fires. A wrong step timer or a wrong state register shifts the rising edge of conv_ready by at least one cycle, and the reference model compares the ports on every clock, so the error is reported in the cycle it happens. A lost or spurious start, such as a missed retrigger, a start during power-down, or an edge accepted during a conversion, changes conv_ready within SYNC_STAGES+1 cycles of the offending request.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_CONV = 1'b1
   } sar_state_t;

   localparam logic REQ_IDLE_LEVEL = 1'b1;
   localparam logic PD_RESET_LEVEL = 1'b0;
endpackage

// File: rtl/sar_req_sync.sv
module sar_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_raw,
   input  logic pd_raw,
   output logic req_s,
   output logic pd_s
);
   import sar_seq_pkg::*;

   generate
      if (STAGES == 0) begin : g_direct
         assign req_s = req_raw;
         assign pd_s  = pd_raw;
      end else begin : g_chain
         logic [STAGES-1:0] req_q;
         logic [STAGES-1:0] pd_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               req_q <= {STAGES{REQ_IDLE_LEVEL}};
               pd_q  <= {STAGES{PD_RESET_LEVEL}};
            end else begin
               req_q[0] <= req_raw;
               pd_q[0]  <= pd_raw;
               for (int i = 1; i < STAGES; i++) begin
                  req_q[i] <= req_q[i-1];
                  pd_q[i]  <= pd_q[i-1];
               end
            end
         end

         assign req_s = req_q[STAGES-1];
         assign pd_s  = pd_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
   parameter int TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic step
);
   generate
      if (TICKS == 1) begin : g_every_cycle
         assign step = run;
      end else begin : g_counter
         localparam int CW = $clog2(TICKS);
         localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clear) begin
               cnt_q <= '0;
            end else if (run) begin
               cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
            end
         end

         assign step = run && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/sar_search_reg.sv
module sar_search_reg #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_msb,
   input  logic         step,
   input  logic         cmp_hi,
   output logic [N-1:0] trial,
   output logic [N-1:0] result,
   output logic         done
);
   localparam int IW = $clog2(N);
   localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};
   localparam logic [IW-1:0] TOP_IDX = IW'(N - 1);

   logic [N-1:0]  trial_q, result_q, trial_nxt;
   logic [IW-1:0] idx_q;
   logic          at_lsb;

   assign at_lsb = (idx_q == '0);

   always_comb begin
      trial_nxt = trial_q;
      if (!cmp_hi) begin
         trial_nxt[idx_q] = 1'b0;
      end
      if (!at_lsb) begin
         trial_nxt[idx_q - IW'(1)] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trial_q  <= '0;
         result_q <= '0;
         idx_q    <= '0;
      end else if (load_msb) begin
         trial_q <= MSB_ONLY;
         idx_q   <= TOP_IDX;
      end else if (step) begin
         if (at_lsb) begin
            trial_q  <= '0;
            result_q <= trial_nxt;
         end else begin
            trial_q <= trial_nxt;
            idx_q   <= idx_q - IW'(1);
         end
      end
   end

   assign trial  = trial_q;
   assign result = result_q;
   assign done   = step && at_lsb;
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
   parameter int RES_BITS      = 16,
   parameter int TICKS_PER_BIT = 8,
   parameter int SYNC_STAGES   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                rc,
   input  logic                pwrdn,
   input  logic                cmp_hi,
   output logic [RES_BITS-1:0] trial_word,
   output logic                conv_ready,
   output logic [RES_BITS-1:0] result_word,
   output logic                result_load
);
   import sar_seq_pkg::*;

   generate
      if (RES_BITS < 2 || RES_BITS > 32) begin : g_bad_res
         $error("sar_seq_ctrl: RES_BITS out of range");
      end
      if (TICKS_PER_BIT < 1) begin : g_bad_ticks
         $error("sar_seq_ctrl: TICKS_PER_BIT must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("sar_seq_ctrl: SYNC_STAGES out of range");
      end
   endgenerate

   logic       req_s, pd_s;
   logic       req_prev_q;
   logic       load_q;
   logic       req_fell, rearm, start, step, done;
   sar_state_t state_q;

   sar_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_raw (cs_n | rc),
      .pd_raw  (pwrdn),
      .req_s   (req_s),
      .pd_s    (pd_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_prev_q <= REQ_IDLE_LEVEL;
      else        req_prev_q <= req_s;
   end

   assign req_fell = req_prev_q && !req_s;
   assign rearm    = load_q && !req_s;
   assign start    = (state_q == ST_IDLE) && !pd_s && (req_fell || rearm);

   sar_step_timer #(.TICKS(TICKS_PER_BIT)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start),
      .run   (state_q == ST_CONV),
      .step  (step)
   );

   sar_search_reg #(.N(RES_BITS)) u_search (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_msb (start),
      .step     (step),
      .cmp_hi   (cmp_hi),
      .trial    (trial_word),
      .result   (result_word),
      .done     (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         load_q  <= 1'b0;
      end else begin
         load_q <= done;
         unique case (state_q)
            ST_IDLE: if (start) state_q <= ST_CONV;
            ST_CONV: if (done)  state_q <= ST_IDLE;
            default:            state_q <= ST_IDLE;
         endcase
      end
   end

   assign conv_ready  = (state_q == ST_IDLE);
   assign result_load = load_q;
endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk #(
   parameter int RES_BITS      = 16,
   parameter int TICKS_PER_BIT = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                conv_ready,
   input logic                result_load,
   input logic [RES_BITS-1:0] result_word,
   input logic [RES_BITS-1:0] trial_word
);
   localparam int BUSY_LEN = RES_BITS * TICKS_PER_BIT;
   localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

   int unsigned low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           low_cnt <= 0;
      else if (!conv_ready) low_cnt <= low_cnt + 1;
      else                  low_cnt <= 0;
   end

   // R3: busy window length
   a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_ready) |-> low_cnt == BUSY_LEN);

   // R4: search begins with the MSB alone
   a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(conv_ready) |-> trial_word == MSB_ONLY);

   // R5: strobe coincides with ready returning high
   a_r5_load_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
      result_load |-> (conv_ready && $rose(conv_ready)));

   // R5: strobe lasts one cycle
   a_r5_load_single: assert property (@(posedge clk) disable iff (!rst_n)
      result_load |=> !result_load);

   // R6: result only changes on a load
   a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      !result_load |-> $stable(result_word));

   // R10: no trial code while idle
   a_r10_trial_idle: assert property (@(posedge clk) disable iff (!rst_n)
      conv_ready |-> trial_word == '0);
endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(
   .RES_BITS      (RES_BITS),
   .TICKS_PER_BIT (TICKS_PER_BIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .conv_ready  (conv_ready),
   .result_load (result_load),
   .result_word (result_word),
   .trial_word  (trial_word)
);

// File: tb/sar_seq_ctrl_test.sv
module sar_seq_ctrl_test;
   localparam int N    = 16;
   localparam int T    = 3;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic rc = 1'b1;
   logic pwrdn = 1'b0;
   logic [N-1:0] vin = '0;
   logic cmp_hi;
   logic [N-1:0] trial_word, result_word;
   logic conv_ready, result_load;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   string phase = "R1";

   always #10 clk = ~clk;

   assign cmp_hi = (trial_word <= vin);

   sar_seq_ctrl #(.RES_BITS(N), .TICKS_PER_BIT(T), .SYNC_STAGES(SYNC)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n        (cs_n),
      .rc          (rc),
      .pwrdn       (pwrdn),
      .cmp_hi      (cmp_hi),
      .trial_word  (trial_word),
      .conv_ready  (conv_ready),
      .result_word (result_word),
      .result_load (result_load)
   );

   // behavioural reference model
   logic hreq [0:SYNC];
   logic hpd  [0:SYNC];
   logic m_prev, m_conv, m_ready, m_load;
   logic [N-1:0] m_trial, m_result;
   int m_idx, m_cnt;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i <= SYNC; i++) begin hreq[i] = 1'b1; hpd[i] = 1'b0; end
         m_prev = 1'b1; m_conv = 1'b0; m_ready = 1'b1; m_load = 1'b0;
         m_trial = '0; m_result = '0; m_idx = 0; m_cnt = 0;
      end else begin
         logic req_e, pd_e, fell, rearm, nload;
         for (int i = SYNC; i > 0; i--) begin hreq[i] = hreq[i-1]; hpd[i] = hpd[i-1]; end
         hreq[0] = cs_n | rc;
         hpd[0]  = pwrdn;
         req_e = hreq[SYNC];
         pd_e  = hpd[SYNC];
         fell  = m_prev && !req_e;
         m_prev = req_e;
         rearm = m_load && !req_e;
         nload = 1'b0;
         if (!m_conv) begin
            if (!pd_e && (fell || rearm)) begin
               m_conv = 1'b1; m_ready = 1'b0; m_idx = N - 1; m_cnt = 0;
               m_trial = '0; m_trial[N-1] = 1'b1;
            end
         end else if (m_cnt == T - 1) begin
            m_cnt = 0;
            if (!(m_trial <= vin)) m_trial[m_idx] = 1'b0;
            if (m_idx == 0) begin
               m_result = m_trial; m_trial = '0; nload = 1'b1;
               m_ready = 1'b1; m_conv = 1'b0;
            end else begin
               m_idx = m_idx - 1;
               m_trial[m_idx] = 1'b1;
            end
         end else begin
            m_cnt = m_cnt + 1;
         end
         m_load = nload;
      end
   end

   task automatic chk(string tag, string name, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s [phase %s] %s actual %h expected %h", tag, phase, name, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // per-cycle comparison and watchdog
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         chk("R3", "conv_ready", N'(conv_ready), N'(m_ready));
         chk("R5", "result_load", N'(result_load), N'(m_load));
         chk("R6", "result_word", result_word, m_result);
         chk("R4", "trial_word", trial_word, m_trial);
      end
      if (cycles > 20000) begin
         fails++;
         $display("FAIL watchdog [phase %s] actual %0d expected %0d", phase, cycles, 20000);
         finish_run();
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_load(logic [N-1:0] expect_val, string tag);
      int guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (!result_load && guard < 1000);
      chk(tag, "loaded result", result_word, expect_val);
   endtask

   initial begin
      idle(4);
      // R1: reset values
      chk("R1", "ready in reset", N'(conv_ready), N'(1));
      chk("R1", "trial in reset", trial_word, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ready after reset", N'(conv_ready), N'(1));
      chk("R1", "load after reset", N'(result_load), N'(0));
      chk("R1", "result after reset", result_word, '0);

      // R2: read/convert falls with chip select low
      phase = "R2";
      vin = 16'hA5C3; cs_n = 1'b0; idle(2);
      rc = 1'b0; idle(3); rc = 1'b1;
      wait_load(16'hA5C3, "R2");
      idle(5);

      // R2: chip select falls with read/convert low
      vin = 16'h0001; cs_n = 1'b1; idle(3);
      rc = 1'b0; idle(3); cs_n = 1'b0; idle(4);
      cs_n = 1'b1; rc = 1'b1;
      wait_load(16'h0001, "R2");
      idle(5);

      // R7: edges during a conversion are ignored
      phase = "R7";
      vin = 16'hFFFF; cs_n = 1'b0; rc = 1'b0; idle(4);
      for (int k = 0; k < 3; k++) begin
         rc = 1'b1; idle(4); rc = 1'b0; idle(4);
      end
      rc = 1'b1;
      wait_load(16'hFFFF, "R7");
      idle(8);
      chk("R7", "no late start", N'(conv_ready), N'(1));

      // R8: request still low at completion restarts at once
      phase = "R8";
      vin = 16'h8000; rc = 1'b0;
      wait_load(16'h8000, "R8");
      vin = 16'h7FFF;
      idle(2);
      chk("R8", "restarted", N'(conv_ready), N'(0));
      idle(3); rc = 1'b1;
      wait_load(16'h7FFF, "R8");
      idle(6);

      // R9: power-down blocks starts, running conversion completes
      phase = "R9";
      pwrdn = 1'b1; idle(4);
      vin = 16'h1234; rc = 1'b0; idle(10);
      chk("R9", "no start in power-down", N'(conv_ready), N'(1));
      pwrdn = 1'b0; idle(10);
      chk("R9", "edge lost", N'(conv_ready), N'(1));
      chk("R9", "result kept", result_word, 16'h7FFF);
      rc = 1'b1; idle(4);
      rc = 1'b0; idle(10); pwrdn = 1'b1; rc = 1'b1;
      wait_load(16'h1234, "R9");
      idle(5); pwrdn = 1'b0;

      // R6 / R10: chip select toggles without a request fall
      phase = "R6";
      vin = 16'h0F0F;
      for (int k = 0; k < 6; k++) begin
         cs_n = ~cs_n; idle(3);
      end
      chk("R6", "result held", result_word, 16'h1234);
      phase = "R10";
      chk("R10", "trial idle", trial_word, '0);
      idle(4);
      finish_run();
   end
endmodule